// File: doc/BRIEF.md
# Serial Word Negator

This block forms the two's complement negation of a binary word that arrives one bit per clock, least significant bit first. The result leaves the block in the same order, one bit per clock, on a serial output. The same bit also shifts into an internal register whose full contents are visible on a parallel output. A one-cycle completion flag marks the cycle in which that register holds the whole negated word.

The block uses no adder and no carry chain. A two-state Mealy machine passes input bits through unchanged up to and including the first 1. From then on it inverts every bit. The states are `NONE_SEEN` (encoding 0: no 1 yet in this word) and `ONE_SEEN` (encoding 1: a 1 has already passed). The transitions are:
- `NONE_SEEN` stays put on an input 0.
- `NONE_SEEN` moves to `ONE_SEEN` on an input 1.
- `ONE_SEEN` stays put on any input.

A start pulse comes with bit 0 of each word. It forces the machine to act as if it were in `NONE_SEEN` for that bit.

A second two-state machine frames the word:
- `PH_IDLE` moves to `PH_RUN` when a start arrives.
- `PH_RUN` returns to `PH_IDLE` when the last bit is accepted.
- A start arriving during `PH_RUN` restarts the word.

Top module: `serneg_top`

## Requirements
- R1: A pulse on `start_i` marks the bit on `din_i` in that cycle as bit 0 (the least significant) of a new word. The block then accepts one bit per clock until `WORD_W` bits have been taken, with no gaps.
- R2: Within a word, every bit up to and including the first 1 is copied unchanged to `sout_o`.
- R3: Within a word, every bit after the first 1 appears inverted on `sout_o`.
- R4: A start pulse, even in the middle of a word, discards the word in progress. The bit arriving with that pulse is treated as bit 0 with no 1 seen yet.
- R5: `sout_o` depends combinationally on the current input bit and state. It is valid in the same cycle as the bit it answers.
- R6: After the last bit of a word, `word_o` equals (2^WORD_W − w) mod 2^WORD_W, where w is the input word. Bit i of `word_o` is bit i of the result.
- R7: `done_o` is high for exactly one cycle: the cycle after the clock edge that accepts the last bit of a word.
- R8: When no word is in progress and `start_i` is low, `din_i` is ignored. In that case `sout_o` is 0, `word_o` keeps its value and `done_o` stays low.
- R9: An all-zero word produces an all-zero result. The most negative word (only the top bit set) produces itself.
- R10: While `rst` is high at a clock edge, the block returns synchronously to `NONE_SEEN` and `PH_IDLE`, and clears `word_o` and `done_o`.
- R11: A start may arrive in the cycle where `done_o` is high. The new word then runs with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock for state, counter and shift register |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Marks bit 0 of a new word |
| din_i | input | 1 | Serial input bit, least significant first |
| sout_o | output | 1 | Serial negated bit for the current input bit |
| word_o | output | WORD_W | Parallel view of the output shift register |
| done_o | output | 1 | One-cycle flag: `word_o` holds a complete result |

## Verification
The hardest case is a restart while the Mealy machine is already in `ONE_SEEN`. Only a start pulse halfway through a word can reach it, and only after a 1 has gone by. The stimulus therefore starts a word with a low-order 1, stops after a few bits and sends a new start. It then checks that the first bit of the new word is copied rather than inverted. The stimulus also starts a word in the same cycle as the completion flag. It inserts idle cycles with a toggling data input, which must leave the parallel word untouched.

// File: rtl/serneg_pkg.sv
package serneg_pkg;

    typedef enum logic {
        NONE_SEEN = 1'b0,
        ONE_SEEN  = 1'b1
    } seen_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/serneg_mealy.sv
module serneg_mealy
    import serneg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    input  logic restart_i,
    input  logic din_i,
    output logic sout_o
);

    seen_e state_q;
    seen_e state_eff;
    seen_e state_d;

    // A restart makes the current bit behave as bit 0 of a fresh word.
    assign state_eff = restart_i ? NONE_SEEN : state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NONE_SEEN;
        end else if (accept_i) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_eff;
        sout_o  = 1'b0;
        if (accept_i) begin
            unique case (state_eff)
                NONE_SEEN: begin
                    sout_o  = din_i;
                    state_d = din_i ? ONE_SEEN : NONE_SEEN;
                end
                ONE_SEEN: begin
                    sout_o  = ~din_i;
                    state_d = ONE_SEEN;
                end
                default: begin
                    sout_o  = 1'b0;
                    state_d = NONE_SEEN;
                end
            endcase
        end
    end

    // Once a 1 has gone out, later bits of the same word come out inverted.
    assert_invert_after_one_R3: assert property (@(posedge clk) disable iff (rst)
        (accept_i && sout_o) |=> ((accept_i && !restart_i) |-> (sout_o != din_i)));

    // A zero emitted before any 1 means the next bit is still copied.
    assert_copy_until_one_R2: assert property (@(posedge clk) disable iff (rst)
        (accept_i && restart_i && !din_i) |=> ((accept_i && !restart_i) |-> (sout_o == din_i)));

    // The bit arriving with a restart is always copied.
    assert_restart_copies_R4: assert property (@(posedge clk) disable iff (rst)
        (accept_i && restart_i) |-> (sout_o == din_i));

    // No output activity outside a word.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !accept_i |-> !sout_o);

endmodule

// File: rtl/serneg_seq.sv
module serneg_seq
    import serneg_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic done_o
);

    localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

    phase_e         phase_q;
    phase_e         phase_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_d;
    logic           done_d;
    logic           last_bit;

    assign accept_o = start_i || (phase_q == PH_RUN);
    assign last_bit = !start_i && (phase_q == PH_RUN) && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done_o  <= done_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d = PH_RUN;
                    cnt_d   = CW'(1);
                end
            end
            PH_RUN: begin
                if (start_i) begin
                    cnt_d = CW'(1);
                end else if (last_bit) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && cnt_q == LAST_IDX && !start_i) |=> done_o);

    assert_start_enters_run_R1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (phase_q == PH_RUN));

endmodule

// File: rtl/serneg_shreg.sv
module serneg_shreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    // Bits enter at the top and move down, so an LSB-first stream lands aligned.
    for (genvar i = 0; i < WORD_W; i++) begin : g_cell
        logic nxt;
        if (i == WORD_W - 1) begin : g_top
            assign nxt = bit_i;
        end else begin : g_mid
            assign nxt = word_o[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                word_o[i] <= 1'b0;
            end else if (shift_i) begin
                word_o[i] <= nxt;
            end
        end
    end

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(word_o));

endmodule

// File: rtl/serneg_top.sv
module serneg_top #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              din_i,
    output logic              sout_o,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);

    logic accept;

    serneg_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .done_o   (done_o)
    );

    serneg_mealy u_mealy (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .restart_i (start_i),
        .din_i     (din_i),
        .sout_o    (sout_o)
    );

    serneg_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .shift_i (accept),
        .bit_i   (sout_o),
        .word_o  (word_o)
    );

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!done_o && word_o == '0));

    assert_idle_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        (!accept && !done_o) |=> !done_o);

endmodule

// File: tb/test_serneg_top.sv
module test_serneg_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         din_i = 1'b0;
    logic         sout_o;
    logic [W-1:0] word_o;
    logic         done_o;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    bit           active = 0;
    int           k = 0;
    logic [W-1:0] acc = '0;
    bit           exp_done = 0;
    logic [W-1:0] exp_par = '0;
    logic [W-1:0] last_par = '0;

    always #4 clk = ~clk;

    serneg_top #(.WORD_W(W)) i_serneg_top (
        .clk(clk), .rst(rst), .start_i(start_i), .din_i(din_i),
        .sout_o(sout_o), .word_o(word_o), .done_o(done_o)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // One clock of stimulus, checked against the arithmetic model.
    task automatic cycle(bit st, bit d);
        logic [W-1:0] neg;
        bit           exp_s;
        @(negedge clk);
        start_i = st;
        din_i   = d;
        #1;
        if (st) begin
            active = 1; k = 0; acc = '0;
        end
        exp_s = 1'b0;
        if (active) begin
            acc[k] = d;
            neg    = -acc;          // bit k of -x depends only on bits 0..k
            exp_s  = neg[k];
        end
        check(sout_o == exp_s, "R2 R3 R5 serial bit", 32'(sout_o), 32'(exp_s));
        check(done_o == exp_done, "R7 done flag", 32'(done_o), 32'(exp_done));
        if (exp_done)
            check(word_o == exp_par, "R6 parallel result", 32'(word_o), 32'(exp_par));
        if (!active && !st)
            check(word_o == last_par, "R8 word held while idle", 32'(word_o), 32'(last_par));
        last_par = word_o;
        exp_done = 0;
        if (active) begin
            k++;
            if (k == W) begin
                active   = 0;
                exp_done = 1;
                exp_par  = -acc;
            end
        end
        @(posedge clk);
        #1;
        if (!active) last_par = word_o;
    endtask

    task automatic send(logic [W-1:0] w, int nbits);
        for (int i = 0; i < nbits; i++) cycle(i == 0, w[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; start_i = 0; din_i = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R10: synchronous reset clears everything
        check(word_o == '0, "R10 word after reset", 32'(word_o), 0);
        check(done_o == 1'b0, "R10 done after reset", 32'(done_o), 0);
        check(sout_o == 1'b0, "R10 sout after reset", 32'(sout_o), 0);
        active = 0; exp_done = 0; last_par = '0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        do_reset();

        // R6 main example: 00001010 -> 11110110
        send(8'h0A, W);
        cycle(0, 0);
        check(last_par == 8'hF6, "R6 example word", 32'(last_par), 32'hF6);

        // R9 all-zero and most negative
        send(8'h00, W); cycle(0, 1);
        send(8'h80, W); cycle(0, 0);
        // R2 R3 edge values
        send(8'hFF, W); cycle(0, 1);
        send(8'h01, W); cycle(0, 0);
        send(8'h7F, W); cycle(0, 1);

        // R8 idle with toggling input
        for (int i = 0; i < 6; i++) cycle(0, i[0]);

        // R4 restart mid-word after a 1 has been seen, then a word starting with 0
        send(8'h03, 3);
        send(8'h5C, W); cycle(0, 0);

        // R11 back-to-back words (start in the done cycle)
        send(8'h12, W);
        send(8'hA5, W);
        send(8'h40, W);
        cycle(0, 0);

        // R1 several further patterns
        for (int j = 0; j < 10; j++) send(8'((j * 37 + 11) ^ (j << 4)), W);
        cycle(0, 0);

        // R10 reset in the middle of a word
        send(8'h2B, 4);
        do_reset();
        cycle(0, 1);
        send(8'h06, W); cycle(0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule